// File: doc/BRIEF.md
# Two-Slow Retimed All-Pole Lattice Filter

This block is an all-pole lattice filter made of `N_STAGES` cascaded stages. Each stage has one reflection coefficient. It performs two multiply-add operations: a forward update that subtracts the scaled backward value from the forward value, and a backward update that adds the scaled new forward value to the delayed backward value. In a direct build the forward path crosses every stage in one cycle, so the logic depth grows with the filter order. Here the array runs two-slow: one filter time step lasts two clock cycles. One register of each doubled backward delay is moved onto the forward path at every stage boundary. As a result, every register-to-register path holds at most two multiply-add operations, whatever the number of stages.

The input stream is slotted. Slots alternate, starting with a "take" slot on the first edge after reset is released. A sample offered on a take slot enters the filter. A take slot with no sample is processed as a zero-valued time step that produces no output. Anything offered on the other slot is discarded. Coefficients are held in registers that load from a packed bus. Arithmetic is signed fixed point with `DW` data bits and `FW` fraction bits, and all sums and products wrap. The design needs `N_STAGES` of at least 2.

Top module: `ar_lattice_sys`

## Requirements
- R1: While reset is active, and in the first cycle after any reset edge, `out_valid` is 0 and `out_data` is 0. All coefficients and all filter state return to zero.
- R2: Samples are taken only on the first rising edge after reset release and on every second edge after that. A high `in_valid` on any other edge has no effect on the outputs.
- R3: A sample taken at edge t yields exactly one output, with `out_valid` high for the one cycle that follows edge t+N_STAGES.
- R4: For each time step, f starts at the input. For stage s from N_STAGES-1 down to 0: f = f - q(k[s], g[s]); then new g[s+1] = q(k[s], f) + g[s]. Finally new g[0] = f and the output is f. Here q(a,b) is bits [FW+DW-1:FW] of the full signed product, and every add or subtract wraps to DW bits.
- R5: A take slot with `in_valid` low is processed as a time step with input 0. The filter state advances, and no `out_valid` pulse results.
- R6: `out_valid` is never high in two consecutive cycles. `out_data` keeps its value in every cycle where `out_valid` is low.
- R7: When `coef_load` is high at an edge, k[s] is loaded from `coef_in` bits [s*DW+DW-1 : s*DW]. When `coef_load` is low, the coefficients keep their values whatever `coef_in` carries.
- R8: With all coefficients zero, which is the state after reset, each output equals its input sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_load | input | 1 | Loads all coefficient registers from `coef_in` |
| coef_in | input | N_STAGES*DW | Packed coefficients, stage s in field s |
| in_valid | input | 1 | Sample offered on this edge |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a new output |
| out_data | output | DW | Signed output sample, held between pulses |

## Verification
The bound checker watches slotting and timing on every cycle. It checks that each `out_valid` pulse sits exactly `N_STAGES` edges after a taken sample, that pulses never touch, that data holds between pulses, that a coefficient load captures the bus, and that reset clears the outputs. Arithmetic correctness can only be shown by the bench scenarios, which compare each output value against a plain step-by-step lattice model. The scenarios cover wraparound at full scale and a coefficient of -2.0, empty take slots that must still advance the state, junk offered on the discard slot, and a zero-coefficient pass-through.

// File: rtl/arl_pkg.sv
package arl_pkg;

    parameter int DW = 16;
    parameter int FW = 14;

    typedef logic signed [DW-1:0] sample_t;

    typedef struct packed {
        logic    vld;
        sample_t val;
    } lane_t;

    typedef enum logic {
        SLOT_TAKE = 1'b0,
        SLOT_SKIP = 1'b1
    } slot_e;

    // Fixed-point product: full signed product, keep bits [FW+DW-1:FW].
    function automatic sample_t qmul(input sample_t a, input sample_t b);
        logic [2*DW-1:0] ax;
        logic [2*DW-1:0] bx;
        logic [2*DW-1:0] p;
        ax = {{DW{a[DW-1]}}, a};
        bx = {{DW{b[DW-1]}}, b};
        p  = ax * bx;
        return sample_t'(p[FW +: DW]);
    endfunction

endpackage

// File: rtl/ar_slot_gate.sv
module ar_slot_gate
    import arl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  sample_t in_data,
    output lane_t   head
);

    slot_e ph;
    logic  take;

    assign take = (ph == SLOT_TAKE) && in_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= SLOT_TAKE;
            head <= '0;
        end else begin
            ph       <= (ph == SLOT_TAKE) ? SLOT_SKIP : SLOT_TAKE;
            // Empty and discard slots feed zero so both lanes stay defined.
            head.vld <= take;
            head.val <= take ? in_data : '0;
        end
    end

endmodule

// File: rtl/ar_fwd_mac.sv
module ar_fwd_mac
    import arl_pkg::*;
(
    input  lane_t   f_in,
    input  sample_t k,
    input  sample_t g_in,
    output lane_t   f_out
);

    always_comb begin
        f_out.vld = f_in.vld;
        f_out.val = sample_t'(f_in.val - qmul(k, g_in));
    end

endmodule

// File: rtl/ar_bwd_mac.sv
module ar_bwd_mac
    import arl_pkg::*;
(
    input  sample_t k,
    input  sample_t f,
    input  sample_t g_in,
    output sample_t g_out
);

    assign g_out = sample_t'(qmul(k, f) + g_in);

endmodule

// File: rtl/ar_lattice_sys.sv
module ar_lattice_sys
    import arl_pkg::*;
#(
    parameter int N_STAGES = 3
)(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         coef_load,
    input  logic [N_STAGES*DW-1:0]       coef_in,
    input  logic                         in_valid,
    input  logic signed [DW-1:0]         in_data,
    output logic                         out_valid,
    output logic signed [DW-1:0]         out_data
);

    localparam int NB = N_STAGES - 1;  // number of stage boundaries

    sample_t coef_q [N_STAGES];
    lane_t   head;
    lane_t   f_reg  [NB];         // forward value registered between stages
    lane_t   f_nxt  [N_STAGES];   // forward result of each stage
    sample_t g_reg  [N_STAGES];   // backward input of each stage
    sample_t g_nxt  [NB];         // backward result feeding the stage above
    sample_t g0_a;                // first of two delays on the bottom turn
    lane_t   out_q;

    // Coefficient registers
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < N_STAGES; s++) coef_q[s] <= '0;
        end else if (coef_load) begin
            for (int s = 0; s < N_STAGES; s++) coef_q[s] <= sample_t'(coef_in[s*DW +: DW]);
        end
    end

    ar_slot_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (sample_t'(in_data)),
        .head     (head)
    );

    for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
        if (s == N_STAGES - 1) begin : g_top
            ar_fwd_mac u_fwd (
                .f_in  (head),
                .k     (coef_q[s]),
                .g_in  (g_reg[s]),
                .f_out (f_nxt[s])
            );
        end else begin : g_inner
            ar_fwd_mac u_fwd (
                .f_in  (f_reg[s]),
                .k     (coef_q[s]),
                .g_in  (g_reg[s]),
                .f_out (f_nxt[s])
            );
            ar_bwd_mac u_bwd (
                .k     (coef_q[s]),
                .f     (f_nxt[s].val),
                .g_in  (g_reg[s]),
                .g_out (g_nxt[s])
            );
        end
    end

    // Retimed delays: one register per boundary on each path, two on the bottom turn.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NB; s++) begin
                f_reg[s]     <= '0;
                g_reg[s + 1] <= '0;
            end
            g0_a     <= '0;
            g_reg[0] <= '0;
            out_q    <= '0;
        end else begin
            for (int s = 0; s < NB; s++) begin
                f_reg[s]     <= f_nxt[s + 1];
                g_reg[s + 1] <= g_nxt[s];
            end
            g0_a      <= f_nxt[0].val;
            g_reg[0]  <= g0_a;
            out_q.vld <= f_nxt[0].vld;
            if (f_nxt[0].vld) out_q.val <= f_nxt[0].val;
        end
    end

    assign out_valid = out_q.vld;
    assign out_data  = out_q.val;

endmodule

// File: rtl/ar_lattice_sys_chk.sv
module ar_lattice_sys_chk
    import arl_pkg::*;
#(
    parameter int N_STAGES = 3
)(
    input logic                   clk,
    input logic                   rst,
    input logic                   coef_load,
    input logic [N_STAGES*DW-1:0] coef_in,
    input logic                   in_valid,
    input logic                   out_valid,
    input logic signed [DW-1:0]   out_data,
    input sample_t                coef_q [N_STAGES]
);

    logic              c_skip;
    logic [N_STAGES:0] hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_skip <= 1'b0;
            hist   <= '0;
        end else begin
            c_skip <= ~c_skip;
            hist   <= {hist[N_STAGES-1:0], (~c_skip & in_valid)};
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    // R2 and R3: pulse exactly N_STAGES edges after a taken sample, none otherwise
    p_latency_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid == hist[N_STAGES]);

    p_no_adjacent_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    p_hold_data_r6: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

    for (genvar s = 0; s < N_STAGES; s++) begin : g_coef
        p_coef_load_r7: assert property (@(posedge clk) disable iff (rst)
            coef_load |=> coef_q[s] == $past(coef_in[s*DW +: DW]));
        p_coef_keep_r7: assert property (@(posedge clk) disable iff (rst)
            !coef_load |=> $stable(coef_q[s]));
    end

endmodule

bind ar_lattice_sys ar_lattice_sys_chk #(.N_STAGES(N_STAGES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .coef_load (coef_load),
    .coef_in   (coef_in),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .coef_q    (coef_q)
);

// File: tb/ar_lattice_sys_tb.sv
module ar_lattice_sys_tb;

    localparam int N  = 3;
    localparam int W  = 16;
    localparam int FB = 14;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 coef_load = 1'b0;
    logic [N*W-1:0]       coef_in = '0;
    logic                 in_valid = 1'b0;
    logic signed [W-1:0]  in_data = '0;
    logic                 out_valid;
    logic signed [W-1:0]  out_data;

    int  cyc = 0;
    bit  bph = 1'b0;
    int  total = 0;
    int  bad = 0;
    string cur_tag = "R4";

    logic signed [W-1:0] kref [N];
    logic signed [W-1:0] gst  [N];
    int exp_val [$];
    int exp_cyc [$];
    int exp_in  [$];

    ar_lattice_sys #(.N_STAGES(N)) u_dut (
        .clk(clk), .rst(rst), .coef_load(coef_load), .coef_in(coef_in),
        .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        bph <= rst ? 1'b0 : ~bph;
    end

    function automatic logic signed [W-1:0] bmul(input logic signed [W-1:0] a,
                                                  input logic signed [W-1:0] b);
        int p;
        p = int'(a) * int'(b);
        return W'(p >>> FB);
    endfunction

    task automatic check(input string tag, input int got, input int expv);
        total++;
        if (got != expv) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d (cycle %0d)", tag, got, expv, cyc);
        end
    endtask

    // Reference: one lattice time step, no retiming.
    task automatic model_step(input logic signed [W-1:0] x, output logic signed [W-1:0] y);
        logic signed [W-1:0] fv [N];
        logic signed [W-1:0] f;
        f = x;
        for (int s = N - 1; s >= 0; s--) begin
            f = W'(f - bmul(kref[s], gst[s]));
            fv[s] = f;
        end
        for (int s = N - 2; s >= 0; s--) gst[s + 1] = W'(bmul(kref[s], fv[s]) + gst[s]);
        gst[0] = fv[0];
        y = fv[0];
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_val.size() == 0) begin
                check("R6 unexpected out_valid", 1, 0);
            end else begin
                check({cur_tag, " out_data"}, int'(out_data), exp_val[0]);
                check("R3 latency", cyc, exp_cyc[0]);
                if (cur_tag == "R8") check("R8 passthrough", int'(out_data), exp_in[0]);
                void'(exp_val.pop_front());
                void'(exp_cyc.pop_front());
                void'(exp_in.pop_front());
            end
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 out_valid in reset", int'(out_valid), 0);
        check("R1 out_data in reset", int'(out_data), 0);
        rst = 1'b0;
        for (int s = 0; s < N; s++) begin
            kref[s] = '0;
            gst[s]  = '0;
        end
    endtask

    task automatic load_coefs(input logic signed [W-1:0] k0, input logic signed [W-1:0] k1,
                              input logic signed [W-1:0] k2);
        coef_load = 1'b1;
        coef_in = {k2, k1, k0};   // R7: stage s at bits s*W
        @(negedge clk);
        coef_load = 1'b0;
        kref[0] = k0; kref[1] = k1; kref[2] = k2;
        coef_in = $urandom();     // R7: ignored while coef_load is low
    endtask

    // One filter time step: take slot then discard slot.
    task automatic slot(input bit v, input logic signed [W-1:0] d,
                        input bit jv, input logic signed [W-1:0] jd);
        logic signed [W-1:0] y;
        if (bph != 1'b0) @(negedge clk);
        in_valid = v;
        in_data  = d;
        model_step(v ? d : '0, y);   // R5: empty take slot steps with zero
        if (v) begin
            exp_val.push_back(int'(y));
            exp_cyc.push_back(cyc + 1 + N);
            exp_in.push_back(int'(d));
        end
        @(negedge clk);
        in_valid = jv;                // R2: ignored on discard slot
        in_data  = jd;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (N + 2) slot(1'b0, '0, 1'b0, '0);
        check("R3 all outputs delivered", exp_val.size(), 0);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));

        // R1, R8, R2: reset state, zero coefficients pass samples through
        cur_tag = "R8";
        do_reset();
        @(negedge clk);
        check("R1 out_valid after release", int'(out_valid), 0);
        for (int i = 0; i < 8; i++)
            slot(1'b1, W'($urandom()), 1'b1, W'($urandom()));
        drain();

        // R4, R5, R7: impulse response with empty slots mixed in
        cur_tag = "R4";
        do_reset();
        load_coefs(16'sd8192, -16'sd4096, 16'sd4915);
        slot(1'b1, 16'sd8192, 1'b0, '0);
        for (int i = 0; i < 24; i++) begin
            if (i % 5 == 2) begin
                cur_tag = "R5";
                slot(1'b0, 16'sd1000, 1'b1, 16'sd20000);
            end else begin
                slot(1'b1, '0, 1'b0, '0);
            end
        end
        drain();

        // R4, R2, R5: random coefficients and stream
        cur_tag = "R4";
        for (int run = 0; run < 3; run++) begin
            do_reset();
            load_coefs(W'(int'($urandom_range(28000)) - 14000),
                       W'(int'($urandom_range(28000)) - 14000),
                       W'(int'($urandom_range(28000)) - 14000));
            for (int i = 0; i < 50; i++)
                slot(($urandom_range(9) < 7), W'($urandom()), $urandom_range(1) == 1, W'($urandom()));
            drain();
        end

        // R4 wraparound corner: k = -2.0 and +max, full-scale inputs
        cur_tag = "R4 wrap";
        do_reset();
        load_coefs(16'sh8000, 16'sh7fff, 16'sh8000);
        slot(1'b1, 16'sh8000, 1'b0, '0);
        slot(1'b1, 16'sh7fff, 1'b0, '0);
        slot(1'b1, 16'sh8000, 1'b1, 16'sh7fff);
        for (int i = 0; i < 6; i++) slot(1'b1, W'($urandom()), 1'b0, '0);
        drain();

        do_reset();
        @(negedge clk);
        check("R1 out_data cleared by reset", int'(out_data), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule